// File: doc/BRIEF.md
# Reconfigurable Haar Wavelet Transform Pipeline

This block computes a non-normalized Haar wavelet transform of a vector of sixteen signed samples that arrive side by side in one beat. It uses adders and subtractors only. A butterfly network of four registered stages works on the vector in place. At each stage the running partial sums pair up into a sum and a difference, and the differences are parked in lanes that later stages leave alone. A single arithmetic right shift by four at the output gives every coefficient the same scale of one sixteenth.

A two-bit mode travels with every vector. The same network can then act as one sixteen-point transform, as two independent eight-point transforms on samples 0–7 and 8–15, or as four independent four-point transforms on consecutive groups of four. In the smaller modes the coarsest stage, or the two coarsest stages, pass their lanes through unchanged. An output mapper then gathers the lanes of each segment so that every segment leaves as a contiguous, ordered block of coefficients.

The block accepts one vector per clock under a valid/ready handshake. It suits a row pass followed at once by a column pass. When the consumer stops taking results, the whole pipeline stalls.

Top module: `haar_xform`

## Requirements
- R1: In mode 0, coefficient 0 equals the sum of all sixteen samples, arithmetically shifted right by 4.
- R2: In mode 0, coefficient 1 is (sum of samples 0–7 minus sum of 8–15); coefficients 2,3 are the 4-sample half differences inside samples 0–7 and 8–15; coefficients 4–7 are the 2-sample half differences inside each group of four; coefficient 8+k is sample 2k minus sample 2k+1. Each is shifted right by 4.
- R3: The shift by 4 rounds toward negative infinity (for example, a raw value of -1 gives -1), and no multiplier is used.
- R4: In mode 1, output block b (indices 8b..8b+7) holds the 8-point transform of samples 8b..8b+7: the segment sum, the half difference, two quarter differences and four pair differences, in that order, each shifted right by 4.
- R5: In mode 2, output block g (indices 4g..4g+3) holds, for samples 4g..4g+3, the group sum, (s0+s1)-(s2+s3), s0-s1 and s2-s3, each shifted right by 4.
- R6: Mode code 3 produces the same result as mode 0.
- R7: A vector accepted at a clock edge appears on the outputs four edges later. With out_ready held high, a new vector is accepted at every edge.
- R8: While out_valid is high and out_ready is low, out_data and out_valid hold, and in_ready is low.
- R9: The mode is captured with each vector, so vectors of different modes in successive cycles are each transformed in their own mode.
- R10: After reset, out_valid is low and in_ready is high.
- R11: Every output coefficient fits in 8 signed bits, sign-extended to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block takes the input at this edge |
| in_mode | input | 2 | 0: 16-point, 1: two 8-point, 2: four 4-point, 3: as 0 |
| in_data | input | 128 | Sample i (8-bit signed) at bits [8i+7:8i] |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Consumer takes the output at this edge |
| out_data | output | 192 | Coefficient i (12-bit signed) at bits [12i+11:12i] |

## Verification
The hardest situation to reach is a stall that lands while a mix of modes fills the pipeline. In that case the mode of each in-flight vector must stay tied to its own data as the stages freeze and resume. The stimulus sends long runs of random vectors with a random mode per vector while out_ready toggles at random. The scoreboard therefore sees stalls begin and end at every pipeline occupancy with mixed modes in flight. Directed vectors with all samples at -1, a lone -1, and alternating extremes cover floor rounding and the range bound.

// File: rtl/haar_pkg.sv
package haar_pkg;

  typedef enum logic [1:0] {
    HM_FULL    = 2'd0,
    HM_HALF    = 2'd1,
    HM_QUARTER = 2'd2,
    HM_ALT     = 2'd3
  } haar_mode_t;

  // Number of coarse stages skipped for a mode
  function automatic int bypass_count(haar_mode_t m);
    case (m)
      HM_HALF:    return 1;
      HM_QUARTER: return 2;
      default:    return 0;
    endcase
  endfunction

  // A stage (1 = finest) combines lanes only when its span fits the segment
  function automatic logic stage_active(int stage, int log_n, haar_mode_t m);
    return stage <= (log_n - bypass_count(m));
  endfunction

  // Lane of the in-place network that feeds output index o
  function automatic int out_lane(int o, int log_n, haar_mode_t m);
    int byp;
    int seg_log;
    int seg;
    int pos;
    int lvl;
    byp = bypass_count(m);
    if (byp > log_n) byp = log_n;
    seg_log = log_n - byp;
    seg = o >> seg_log;
    pos = o & ((1 << seg_log) - 1);
    if (pos == 0) return seg;
    lvl = 0;
    for (int i = 0; i < 16; i++) begin
      if ((pos >> i) != 0) lvl = i;
    end
    return (((1 << byp) + seg) << lvl) + pos - (1 << lvl);
  endfunction

  // Pair node arithmetic, widened by one bit
  function automatic logic signed [31:0] node_sum(logic signed [31:0] a, logic signed [31:0] b);
    return a + b;
  endfunction

  function automatic logic signed [31:0] node_diff(logic signed [31:0] a, logic signed [31:0] b);
    return a - b;
  endfunction

endpackage

// File: rtl/haar_stage.sv
module haar_stage
  import haar_pkg::*;
#(
  parameter int N     = 16,
  parameter int LOG_N = 4,
  parameter int IW    = 8,
  parameter int STAGE = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  haar_mode_t          mode_i,
  input  logic [N*IW-1:0]     data_i,
  output haar_mode_t          mode_o,
  output logic [N*(IW+1)-1:0] data_o
);

  localparam int OW   = IW + 1;
  localparam int SPAN = N >> (STAGE - 1);
  localparam int HALF = SPAN / 2;

  logic            active;
  logic [N*OW-1:0] nxt;

  assign active = stage_active(STAGE, LOG_N, mode_i);

  for (genvar l = 0; l < N; l++) begin : g_lane
    logic signed [OW-1:0] pass;
    assign pass = {data_i[(l+1)*IW-1], data_i[l*IW +: IW]};

    if (l < HALF) begin : g_sum
      logic signed [31:0] x0, x1, r;
      assign x0 = 32'(signed'(data_i[(2*l)*IW +: IW]));
      assign x1 = 32'(signed'(data_i[(2*l+1)*IW +: IW]));
      assign r  = node_sum(x0, x1);
      assign nxt[l*OW +: OW] = active ? r[OW-1:0] : pass;
    end else if (l < SPAN) begin : g_diff
      localparam int J = l - HALF;
      logic signed [31:0] x0, x1, r;
      assign x0 = 32'(signed'(data_i[(2*J)*IW +: IW]));
      assign x1 = 32'(signed'(data_i[(2*J+1)*IW +: IW]));
      assign r  = node_diff(x0, x1);
      assign nxt[l*OW +: OW] = active ? r[OW-1:0] : pass;
    end else begin : g_keep
      assign nxt[l*OW +: OW] = pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      mode_o <= HM_FULL;
    end else if (en) begin
      data_o <= nxt;
      mode_o <= mode_i;
    end
  end

endmodule

// File: rtl/haar_outmap.sv
module haar_outmap
  import haar_pkg::*;
#(
  parameter int N     = 16,
  parameter int LOG_N = 4,
  parameter int FW    = 12,
  parameter int CW    = 12
) (
  input  haar_mode_t      mode_i,
  input  logic [N*FW-1:0] data_i,
  output logic [N*CW-1:0] data_o
);

  for (genvar o = 0; o < N; o++) begin : g_out
    int                   lane;
    logic signed [FW-1:0] picked;
    logic signed [FW-1:0] scaled;
    assign lane   = out_lane(o, LOG_N, mode_i);
    assign picked = data_i[lane*FW +: FW];
    assign scaled = picked >>> LOG_N;
    assign data_o[o*CW +: CW] = CW'(scaled);
  end

endmodule

// File: rtl/haar_xform.sv
module haar_xform
  import haar_pkg::*;
#(
  parameter int LOG_N = 4,
  parameter int SW    = 8,
  parameter int CW    = SW + LOG_N
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_mode,
  input  logic [(1<<LOG_N)*SW-1:0]   in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [(1<<LOG_N)*CW-1:0]   out_data
);

  localparam int N  = 1 << LOG_N;
  localparam int FW = SW + LOG_N;

  logic             advance;
  logic             accept;
  logic             deliver;
  logic [LOG_N-1:0] vld;

  assign advance   = out_ready | ~vld[LOG_N-1];
  assign in_ready  = advance;
  assign accept    = in_valid & advance;
  assign out_valid = vld[LOG_N-1];
  assign deliver   = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (advance) vld <= {vld[LOG_N-2:0], in_valid};
  end

  for (genvar k = 1; k <= LOG_N; k++) begin : g_stg
    localparam int IW = SW + k - 1;
    logic [N*IW-1:0]     d_in;
    logic [N*(IW+1)-1:0] d_out;
    haar_mode_t          m_in;
    haar_mode_t          m_out;
    if (k == 1) begin : g_first
      assign d_in = in_data;
      assign m_in = haar_mode_t'(in_mode);
    end else begin : g_next
      assign d_in = g_stg[k-1].d_out;
      assign m_in = g_stg[k-1].m_out;
    end
    haar_stage #(.N(N), .LOG_N(LOG_N), .IW(IW), .STAGE(k)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (advance),
      .mode_i(m_in),
      .data_i(d_in),
      .mode_o(m_out),
      .data_o(d_out)
    );
  end

  haar_outmap #(.N(N), .LOG_N(LOG_N), .FW(FW), .CW(CW)) u_outmap (
    .mode_i(g_stg[LOG_N].m_out),
    .data_i(g_stg[LOG_N].d_out),
    .data_o(out_data)
  );

endmodule

// File: rtl/haar_xform_chk.sv
module haar_xform_chk #(
  parameter int LOG_N = 4,
  parameter int SW    = 8,
  parameter int CW    = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       accept,
  input logic                       deliver,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [(1<<LOG_N)*CW-1:0]   out_data
);

  localparam int N  = 1 << LOG_N;
  localparam int XB = CW - SW + 1;

  logic [7:0] occ;
  logic       range_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + 8'(accept) - 8'(deliver);
  end

  always_comb begin
    range_ok = 1'b1;
    for (int o = 0; o < N; o++) begin
      if (out_data[o*CW+SW-1 +: XB] != '0 && out_data[o*CW+SW-1 +: XB] != '1)
        range_ok = 1'b0;
    end
  end

  // R8: a refused result stays put
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a full, stalled pipeline refuses input
  a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10: an empty output stage never refuses input
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: never more vectors in flight than stages
  a_r7_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 8'(LOG_N));

  // R7: a result can only exist for an accepted vector
  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ != 8'd0));

  // R11: coefficients are sign extensions of 8-bit values
  a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> range_ok);

endmodule

bind haar_xform haar_xform_chk #(.LOG_N(LOG_N), .SW(SW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .deliver  (deliver),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/test_haar_xform.sv
module test_haar_xform;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 4;
  localparam int N     = 16;
  localparam int SW    = 8;
  localparam int CW    = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [1:0]      in_mode = 2'd0;
  logic [N*SW-1:0] in_data = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [N*CW-1:0] out_data;

  haar_xform #(.LOG_N(LOG_N), .SW(SW), .CW(CW)) i_haar_xform (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [N*CW-1:0] data;
    int              cyc;
    bit              lat;
    string           tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   stall_mode = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic int sample(input logic [N*SW-1:0] v, input int i);
    logic signed [SW-1:0] s;
    s = v[i*SW +: SW];
    return int'(s);
  endfunction

  function automatic int range_sum(input logic [N*SW-1:0] v, input int start, input int cnt);
    int acc = 0;
    for (int i = start; i < start + cnt; i++) acc += sample(v, i);
    return acc;
  endfunction

  // Coefficients restated from the requirements: blocks of halving width
  function automatic logic [N*CW-1:0] model(input logic [N*SW-1:0] v, input logic [1:0] m);
    logic [N*CW-1:0] r;
    int byp, segn;
    byp  = (m == 2'd1) ? 1 : (m == 2'd2) ? 2 : 0;
    segn = N >> byp;
    for (int o = 0; o < N; o++) begin
      int seg, pos, val, l, w, b, st;
      seg = o / segn;
      pos = o % segn;
      if (pos == 0) begin
        val = range_sum(v, seg*segn, segn);
      end else begin
        l = 0;
        while ((2 << l) <= pos) l++;
        w  = segn >> l;
        b  = pos - (1 << l);
        st = seg*segn + b*w;
        val = range_sum(v, st, w/2) - range_sum(v, st + w/2, w/2);
      end
      val = val >>> 4;
      r[o*CW +: CW] = CW'(val);
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R1 R2";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic send(input logic [N*SW-1:0] v, input logic [1:0] m, input bit lat,
                      input string tag, output int waits);
    exp_t e;
    waits = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    in_mode  = m;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
      waits++;
    end
    e.data = model(v, m);
    e.cyc  = cyc;
    e.lat  = lat;
    e.tag  = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [N*SW-1:0] fill(input int a);
    logic [N*SW-1:0] r;
    for (int i = 0; i < N; i++) r[i*SW +: SW] = SW'(a);
    return r;
  endfunction

  // Scoreboard monitor
  initial begin
    logic [N*CW-1:0] prev_data;
    bit              prev_stall;
    prev_stall = 1'b0;
    prev_data  = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R8",
                $sformatf("held output changed: act=%h exp=%h", out_data, prev_data));
        if (out_valid && !out_ready)
          check(!in_ready, "R8", $sformatf("in_ready act=%0b exp=0", in_ready));
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7", "output without accepted input: act=valid exp=none");
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_data == e.data, e.tag,
                  $sformatf("data act=%h exp=%h", out_data, e.data));
            if (e.lat)
              check(cyc - e.cyc == 4, "R7",
                    $sformatf("latency act=%0d exp=4", cyc - e.cyc));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  // Random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (stall_mode) out_ready = ($urandom % 3) != 0;
      else            out_ready = 1'b1;
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog expired: act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    logic [N*SW-1:0] v;
    repeat (3) @(negedge clk);
    #2;
    // R10: reset state
    check(out_valid == 1'b0, "R10", $sformatf("out_valid act=%0b exp=0", out_valid));
    check(in_ready == 1'b1, "R10", $sformatf("in_ready act=%0b exp=1", in_ready));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10",
          $sformatf("after release valid=%0b ready=%0b exp 0/1", out_valid, in_ready));

    // Ramp in 16-point mode (R1, R2)
    for (int i = 0; i < N; i++) v[i*SW +: SW] = SW'(i);
    send(v, 2'd0, 1'b1, "R1 R2", w);
    // Floor rounding (R3): all -1 and a lone -1
    send(fill(-1), 2'd0, 1'b1, "R3", w);
    v = '0; v[0 +: SW] = 8'hFF;
    send(v, 2'd0, 1'b1, "R3", w);
    v = '0; v[15*SW +: SW] = 8'hFF;
    send(v, 2'd2, 1'b1, "R3 R5", w);
    // Extremes (R11, R2)
    send(fill(127), 2'd0, 1'b1, "R11 R1", w);
    send(fill(-128), 2'd0, 1'b1, "R11 R1", w);
    for (int i = 0; i < N; i++) v[i*SW +: SW] = (i % 2 == 0) ? 8'sd127 : -8'sd128;
    send(v, 2'd0, 1'b1, "R11 R2", w);
    for (int i = 0; i < N; i++) v[i*SW +: SW] = (i < 8) ? 8'sd127 : -8'sd128;
    send(v, 2'd0, 1'b1, "R11 R2", w);
    // Split modes and the spare code
    for (int i = 0; i < N; i++) v[i*SW +: SW] = SW'(i*i - 3*i);
    send(v, 2'd1, 1'b1, "R4", w);
    send(v, 2'd2, 1'b1, "R5", w);
    send(v, 2'd3, 1'b1, "R6", w);
    send(v, 2'd0, 1'b1, "R6 R1", w);
    idle();
    repeat (6) @(negedge clk);

    // Back-to-back burst with mixed modes (R7, R9)
    for (int k = 0; k < 24; k++) begin
      for (int i = 0; i < N; i++) v[i*SW +: SW] = SW'($urandom);
      send(v, 2'(k % 4), 1'b1, "R9", w);
      check(w == 0, "R7", $sformatf("waits act=%0d exp=0", w));
    end
    idle();
    repeat (6) @(negedge clk);

    // Random stalls with random modes (R8, R9)
    stall_mode = 1'b1;
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < N; i++) v[i*SW +: SW] = SW'($urandom);
      send(v, 2'($urandom), 1'b0, "R8 R9", w);
      if ($urandom % 4 == 0) begin
        idle();
      end
    end
    idle();
    stall_mode = 1'b0;
    repeat (12) @(negedge clk);
    check(sb.size() == 0, "R7", $sformatf("pending act=%0d exp=0", sb.size()));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule